// File: doc/BRIEF.md
# Sine-Fit SNDR Pass/Fail Analyzer

This block judges the digital output of a converter under test against a reference sinusoid. The reference has the same frequency as the stimulus, and a delay stage outside the block aligns it in time with the response, so the block never estimates phase. After a start request the block makes two passes over two periods of the stimulus. The first pass collects the sum of the samples and their correlation with the reference. From these it derives the offset, the response amplitude and a gain that scales the reference. The second pass collects the squared error between each sample and the scaled, offset reference. A single comparison of signal power against scaled error power then gives a go or no-go verdict, with no logarithm.

Each pass covers N = 2^LOG2_N accepted samples and begins on the period-start strobe. Two preloaded inputs carry the known reference amplitude and the limit. The amplitude arrives as a fixed-point reciprocal, `amp_recip_i = round(2^FRAC_W / Aref)`. The limit arrives as a plain integer power ratio, `thresh_i = 10^(spec/10)`.

The control is a state machine with five states:
- `ST_IDLE` moves to `ST_SUM` on `start_i`.
- `ST_SUM` moves to `ST_DERIVE` on the N-th accepted sample.
- `ST_DERIVE` lasts one cycle and moves to `ST_RESID`.
- `ST_RESID` moves to `ST_JUDGE` on the N-th accepted sample.
- `ST_JUDGE` lasts one cycle and returns to `ST_IDLE`, which registers the verdict and the done pulse.

Top module: `sndr_fit_analyzer`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy_o`, `done_o` and `go_o` are 0.
- R2: A `start_i` high while idle makes `busy_o` 1 from the next cycle on and clears `go_o`. A `start_i` while busy has no effect on the run or on its verdict.
- R3: A pass starts only on a sample with `smp_valid_i`=1 and `smp_sync_i`=1. Samples with `smp_valid_i`=0 are skipped, and so are valid samples that arrive before the strobe. A pass ends after N accepted samples.
- R4: In the first pass, S = Σout and C = Σout·ref. Then dc = floor(S/N), amp = floor(C·amp_recip / 2^(LOG2_N−1+FRAC_W)) and gain = amp·amp_recip. All values are signed integers with floor division.
- R5: In the second pass, adj = floor(gain·ref / 2^FRAC_W) + dc and E = Σ(out − adj)².
- R6: The verdict `go_o` is 1 exactly when amp²·N > 2·E·thresh_i. This is a strict comparison, so equality gives 0.
- R7: `done_o` is a pulse of one cycle. It appears two clock edges after the edge that accepts the last sample of the second pass, and `busy_o` is 0 in that cycle.
- R8: `go_o` holds its value from the done pulse until the next accepted start, and it is 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_sync_i | input | 1 | Marks the first sample of a stimulus period |
| smp_out_i | input | SMP_W | Converter output sample, signed |
| smp_ref_i | input | REF_W | Aligned reference sample, signed |
| amp_recip_i | input | FRAC_W+1 | Unsigned round(2^FRAC_W / Aref) |
| thresh_i | input | THR_W | Unsigned power-ratio limit |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle verdict strobe |
| go_o | output | 1 | Verdict: 1 = pass |

## Verification
The hardest point to reach from the ports is the exact edge of the verdict, where amp²·N lies just above or just below 2·E·thresh_i. To reach it, the bench computes amp and E for a mildly noisy signal. It then runs that signal twice, with thresh_i set to the floor of the ratio and to one more than that. The expected verdict flips between the two runs, which pins every bit of the offset, gain and error arithmetic. Other runs bring the strobe alignment and the ignored samples into play. They insert junk samples before the strobe, put gaps in a pass and pulse start in the middle of a run, and each must give the same verdict as the clean run.

// File: rtl/sndr_fit_pkg.sv
package sndr_fit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_DERIVE,
        ST_RESID,
        ST_JUDGE
    } fit_state_e;
endpackage

// File: rtl/sndr_fit_ctrl.sv
module sndr_fit_ctrl
    import sndr_fit_pkg::*;
#(
    parameter int LOG2_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic smp_valid_i,
    input  logic smp_sync_i,
    output logic clr_o,
    output logic take_o,
    output logic pass2_o,
    output logic load_o,
    output logic judge_o,
    output logic busy_o
);
    localparam int N = 1 << LOG2_N;
    localparam logic [LOG2_N-1:0] LAST_IDX = LOG2_N'(N - 1);

    fit_state_e st, nx;
    logic [LOG2_N-1:0] cnt;
    logic last;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr_o)  cnt <= '0;
        else if (take_o) cnt <= last ? '0 : cnt + 1'b1;
    end

    always_comb begin
        nx      = st;
        clr_o   = 1'b0;
        take_o  = 1'b0;
        pass2_o = 1'b0;
        load_o  = 1'b0;
        judge_o = 1'b0;
        last    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_i) begin
                    clr_o = 1'b1;
                    nx    = ST_SUM;
                end
            end
            ST_SUM: begin
                take_o = smp_valid_i && (cnt != '0 || smp_sync_i);
                last   = take_o && (cnt == LAST_IDX);
                if (last) nx = ST_DERIVE;
            end
            ST_DERIVE: begin
                load_o = 1'b1;
                nx     = ST_RESID;
            end
            ST_RESID: begin
                pass2_o = 1'b1;
                take_o  = smp_valid_i && (cnt != '0 || smp_sync_i);
                last    = take_o && (cnt == LAST_IDX);
                if (last) nx = ST_JUDGE;
            end
            ST_JUDGE: begin
                judge_o = 1'b1;
                nx      = ST_IDLE;
            end
            default: nx = ST_IDLE;
        endcase
        busy_o = (st != ST_IDLE);
    end
endmodule

// File: rtl/sndr_fit_accum.sv
module sndr_fit_accum #(
    parameter int SMP_W  = 12,
    parameter int REF_W  = 12,
    parameter int LOG2_N = 4,
    parameter int FRAC_W = 16,
    parameter int SUM_W  = SMP_W + LOG2_N,
    parameter int COR_W  = SMP_W + REF_W + LOG2_N,
    parameter int GN_W   = 44,
    parameter int ERR_W  = 42,
    parameter int E_W    = 88
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    take_i,
    input  logic                    pass2_i,
    input  logic signed [SMP_W-1:0] smp_out_i,
    input  logic signed [REF_W-1:0] smp_ref_i,
    input  logic signed [GN_W-1:0]  gain_i,
    input  logic signed [SMP_W-1:0] dc_i,
    output logic signed [SUM_W-1:0] sum_o,
    output logic signed [COR_W-1:0] corr_o,
    output logic signed [E_W-1:0]   err_o
);
    localparam int SC_W = GN_W + REF_W;

    logic signed [COR_W-1:0] prod;
    logic signed [SC_W-1:0]  scaled;
    logic signed [ERR_W-1:0] adj, diff;
    logic signed [E_W-1:0]   sq;

    always_comb begin
        prod   = COR_W'(smp_out_i) * COR_W'(smp_ref_i);
        scaled = SC_W'(gain_i) * SC_W'(smp_ref_i);
        adj    = ERR_W'(scaled >>> FRAC_W) + ERR_W'(dc_i);
        diff   = ERR_W'(smp_out_i) - adj;
        sq     = E_W'(diff) * E_W'(diff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sum_o  <= '0;
            corr_o <= '0;
            err_o  <= '0;
        end else if (take_i) begin
            if (pass2_i) begin
                err_o <= err_o + sq;
            end else begin
                sum_o  <= sum_o + SUM_W'(smp_out_i);
                corr_o <= corr_o + prod;
            end
        end
    end
endmodule

// File: rtl/sndr_fit_math.sv
module sndr_fit_math #(
    parameter int SMP_W  = 12,
    parameter int LOG2_N = 4,
    parameter int FRAC_W = 16,
    parameter int THR_W  = 24,
    parameter int SUM_W  = 16,
    parameter int COR_W  = 28,
    parameter int AMP_W  = 26,
    parameter int GN_W   = 44,
    parameter int E_W    = 88
) (
    input  logic signed [SUM_W-1:0] sum_i,
    input  logic signed [COR_W-1:0] corr_i,
    input  logic [FRAC_W:0]         recip_i,
    input  logic signed [AMP_W-1:0] amp_r_i,
    input  logic signed [E_W-1:0]   err_i,
    input  logic [THR_W-1:0]        thr_i,
    output logic signed [SMP_W-1:0] dc_o,
    output logic signed [AMP_W-1:0] amp_o,
    output logic signed [GN_W-1:0]  gain_o,
    output logic                    pass_o
);
    localparam int P1_W  = COR_W + FRAC_W + 2;
    localparam int CMP_W = E_W + THR_W + 2;

    logic signed [P1_W-1:0]  p1;
    logic signed [CMP_W-1:0] sig_pw, err_pw;

    always_comb begin
        p1     = P1_W'(corr_i) * P1_W'($signed({1'b0, recip_i}));
        amp_o  = AMP_W'(p1 >>> (LOG2_N - 1 + FRAC_W));
        gain_o = GN_W'(amp_o) * GN_W'($signed({1'b0, recip_i}));
        dc_o   = SMP_W'(sum_i >>> LOG2_N);
        sig_pw = (CMP_W'(amp_r_i) * CMP_W'(amp_r_i)) <<< LOG2_N;
        err_pw = (CMP_W'(err_i) * CMP_W'($signed({1'b0, thr_i}))) <<< 1;
        pass_o = sig_pw > err_pw;
    end
endmodule

// File: rtl/sndr_fit_analyzer.sv
module sndr_fit_analyzer #(
    parameter int SMP_W  = 12,
    parameter int REF_W  = 12,
    parameter int LOG2_N = 4,
    parameter int FRAC_W = 16,
    parameter int THR_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    smp_valid_i,
    input  logic                    smp_sync_i,
    input  logic signed [SMP_W-1:0] smp_out_i,
    input  logic signed [REF_W-1:0] smp_ref_i,
    input  logic [FRAC_W:0]         amp_recip_i,
    input  logic [THR_W-1:0]        thresh_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    go_o
);
    localparam int SUM_W = SMP_W + LOG2_N;
    localparam int COR_W = SMP_W + REF_W + LOG2_N;
    localparam int AMP_W = SMP_W + REF_W + 2;
    localparam int GN_W  = AMP_W + FRAC_W + 2;
    localparam int ERR_W = GN_W + REF_W - FRAC_W + 2;
    localparam int E_W   = 2 * ERR_W + LOG2_N;

    logic clr, take, pass2, load, judge, busy, verdict;
    logic signed [SUM_W-1:0] sum_s;
    logic signed [COR_W-1:0] corr_c;
    logic signed [E_W-1:0]   err_e;
    logic signed [SMP_W-1:0] dc_n, dc_r;
    logic signed [AMP_W-1:0] amp_n, amp_r;
    logic signed [GN_W-1:0]  gain_n, gain_r;
    logic go_q, done_q;

    sndr_fit_ctrl #(.LOG2_N(LOG2_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .smp_valid_i(smp_valid_i), .smp_sync_i(smp_sync_i),
        .clr_o(clr), .take_o(take), .pass2_o(pass2),
        .load_o(load), .judge_o(judge), .busy_o(busy)
    );

    sndr_fit_accum #(
        .SMP_W(SMP_W), .REF_W(REF_W), .LOG2_N(LOG2_N), .FRAC_W(FRAC_W),
        .SUM_W(SUM_W), .COR_W(COR_W), .GN_W(GN_W), .ERR_W(ERR_W), .E_W(E_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .take_i(take), .pass2_i(pass2),
        .smp_out_i(smp_out_i), .smp_ref_i(smp_ref_i),
        .gain_i(gain_r), .dc_i(dc_r),
        .sum_o(sum_s), .corr_o(corr_c), .err_o(err_e)
    );

    sndr_fit_math #(
        .SMP_W(SMP_W), .LOG2_N(LOG2_N), .FRAC_W(FRAC_W), .THR_W(THR_W),
        .SUM_W(SUM_W), .COR_W(COR_W), .AMP_W(AMP_W), .GN_W(GN_W), .E_W(E_W)
    ) u_math (
        .sum_i(sum_s), .corr_i(corr_c), .recip_i(amp_recip_i),
        .amp_r_i(amp_r), .err_i(err_e), .thr_i(thresh_i),
        .dc_o(dc_n), .amp_o(amp_n), .gain_o(gain_n), .pass_o(verdict)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_r   <= '0;
            amp_r  <= '0;
            gain_r <= '0;
        end else if (load) begin
            dc_r   <= dc_n;
            amp_r  <= amp_n;
            gain_r <= gain_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= judge;
            if (clr)        go_q <= 1'b0;
            else if (judge) go_q <= verdict;
        end
    end

    assign busy_o = busy;
    assign done_o = done_q;
    assign go_o   = go_q;
endmodule

// File: rtl/sndr_fit_analyzer_sva.sv
module sndr_fit_analyzer_sva (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic go_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !go_o));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_go_low_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !go_o);

    assert_go_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(go_o));
endmodule

bind sndr_fit_analyzer sndr_fit_analyzer_sva u_sva (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .go_o(go_o)
);

// File: tb/sndr_fit_analyzer_test.sv
module sndr_fit_analyzer_test;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, smp_valid_i = 1'b0, smp_sync_i = 1'b0;
    logic signed [11:0] smp_out_i = '0, smp_ref_i = '0;
    logic [16:0] amp_recip_i = 17'd66;
    logic [23:0] thresh_i = '0;
    logic busy_o, done_o, go_o;

    int nchk = 0, nerr = 0, ndone = 0;
    bit exp_q[$];
    longint o_a[N], r_a[N];

    always #4 clk = ~clk;

    sndr_fit_analyzer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .smp_valid_i(smp_valid_i), .smp_sync_i(smp_sync_i),
        .smp_out_i(smp_out_i), .smp_ref_i(smp_ref_i),
        .amp_recip_i(amp_recip_i), .thresh_i(thresh_i),
        .busy_o(busy_o), .done_o(done_o), .go_o(go_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: verdict at each done strobe (R6)
    always @(negedge clk) begin
        if (done_o) begin
            ndone++;
            if (exp_q.size() == 0) chk("R7 unexpected done", 1, 0);
            else chk("R6 verdict", go_o, exp_q.pop_front());
        end
    end

    task automatic build(input real amp, input longint dc, input longint nscale);
        for (int i = 0; i < N; i++) begin
            real ph;
            ph = 2.0 * 3.14159265358979 * i / N;
            r_a[i] = longint'($floor(1000.0 * $sin(ph) + 0.5));
            o_a[i] = longint'($floor(amp * $sin(ph) + 0.5)) + dc
                     + (((i * 7) % 5) - 2) * nscale;
        end
    endtask

    // model from R4, R5: returns signal term amp^2*N and error term 2*E
    task automatic stats(output longint sig, output longint e2);
        longint s, c, dc, amp, gain, e, adj;
        s = 0; c = 0; e = 0;
        for (int i = 0; i < N; i++) begin
            s += o_a[i];
            c += o_a[i] * r_a[i];
        end
        dc   = s >>> 4;
        amp  = (c * longint'(amp_recip_i)) >>> 19;
        gain = amp * longint'(amp_recip_i);
        for (int i = 0; i < N; i++) begin
            adj = ((gain * r_a[i]) >>> 16) + dc;
            e += (o_a[i] - adj) * (o_a[i] - adj);
        end
        sig = amp * amp * N;
        e2  = 2 * e;
    endtask

    task automatic drive_pass(input bit junk, input bit gaps, input bit restart);
        if (junk) begin
            for (int j = 0; j < 3; j++) begin
                smp_valid_i = 1'b1; smp_sync_i = 1'b0;
                smp_out_i = 12'sd1500; smp_ref_i = -12'sd900;
                @(negedge clk);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (gaps && (i % 5 == 2)) begin
                smp_valid_i = 1'b0; smp_out_i = 12'sd2000;
                @(negedge clk);
            end
            smp_valid_i = 1'b1;
            smp_sync_i  = (i == 0);
            smp_out_i   = 12'(o_a[i]);
            smp_ref_i   = 12'(r_a[i]);
            start_i     = restart && (i == 8);
            @(negedge clk);
        end
        smp_valid_i = 1'b0; smp_sync_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic run_case(input string name, input longint thr,
                            input bit junk, input bit gaps, input bit restart);
        longint sig, e2;
        bit exp_go;
        thresh_i = 24'(thr);
        stats(sig, e2);
        exp_go = sig > e2 * thr;
        exp_q.push_back(exp_go);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({"R2 busy after start ", name}, busy_o, 1);
        chk({"R8 go cleared on start ", name}, go_o, 0);
        drive_pass(junk, gaps, restart);
        @(negedge clk);
        drive_pass(junk, gaps, 1'b0);
        chk({"R7 no done one edge after last ", name}, done_o, 0);
        chk({"R2 still busy ", name}, busy_o, 1);
        @(negedge clk);
        chk({"R7 done two edges after last ", name}, done_o, 1);
        @(negedge clk);
        chk({"R7 done is one cycle ", name}, done_o, 0);
        repeat (4) @(negedge clk);
        chk({"R8 go held ", name}, go_o, exp_go);
    endtask

    initial begin
        longint sig, e2, thr_b;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 done in reset", done_o, 0);
        chk("R1 go in reset", go_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy_o, 0);

        build(800.0, 20, 0);
        run_case("clean", 1000, 0, 0, 0);
        chk("R6 clean passes", go_o, 1);

        build(800.0, 20, 200);
        run_case("noisy", 1000000, 0, 0, 0);
        chk("R6 noisy fails", go_o, 0);

        build(700.0, -35, 3);
        stats(sig, e2);
        thr_b = sig / e2;
        run_case("boundary below", thr_b, 0, 0, 0);
        chk("R6 R5 R4 boundary floor passes", go_o, 1);
        run_case("boundary above", thr_b + 1, 0, 0, 0);
        chk("R6 R5 R4 boundary plus one fails", go_o, 0);

        build(800.0, 20, 0);
        run_case("junk and gaps", 1000, 1, 1, 0);
        chk("R3 junk and gaps same verdict", go_o, 1);

        build(-600.0, 45, 2);
        run_case("inverted restart", 500, 0, 0, 1);
        chk("R2 restart ignored verdict", go_o, 1);

        chk("R7 done count", ndone, 6);
        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule